// File: doc/BRIEF.md
# Runahead Load Resolver with Poison Tracking

This block settles, for each load issued while the core runs ahead past a blocking miss, where the load's value comes from and whether its destination register is poisoned. A poisoned register holds a bogus value. The block also keeps the poison flags of the physical registers, and it decides when the instruction at the head of the window may pseudo-retire. It flags the state changes of runahead stores in the store buffer.

The store buffer, the runahead cache and the first-level data cache are looked up in parallel, and their results arrive on the ports in the same cycle as the load. The block picks a source in a fixed order: store buffer, then runahead cache, then data cache. If all three miss, it requests the line from the second-level cache and waits. In runahead mode a second-level miss poisons the load and drops it from the scheduler instead of stalling it. The memory request still goes out as a prefetch.

The load engine is a two-state machine. State `LS_IDLE` accepts and resolves loads. On a miss in all three structures, transition `issue_l2` leads to `LS_L2_WAIT`. From there, transition `l2_fill` (second-level hit) or `l2_poison` (second-level miss in runahead mode) returns to `LS_IDLE`. Transition `l2_stall` (second-level miss in normal mode) stays in `LS_L2_WAIT`.

Top module: `ra_load_resolve`

## Requirements
- R1: A load accepted in LS_IDLE whose source register is poisoned completes in the same cycle with destination poisoned and data 0. It makes no second-level request, and all lookup inputs are ignored.
- R2: A clean load that hits a store-buffer entry marked valid completes with that entry's data, destination clean, whatever the runahead cache and data cache report.
- R3: A clean load that hits a store-buffer entry marked poisoned completes with destination poisoned and data 0, whatever the other lookups report.
- R4: A clean load that misses the store buffer and hits the runahead cache takes the runahead-cache data with destination clean. The exception is when any byte selected by its byte mask has its poison bit set (bit i of the poison and mask vectors is byte i). In that case it completes poisoned with data 0. Poison bits of bytes outside the mask have no effect.
- R5: A clean load that misses the store buffer and the runahead cache but hits the data cache completes with the data-cache data, destination clean.
- R6: A clean load that misses all three structures raises the second-level request for exactly that cycle and moves to LS_L2_WAIT. Ready is low in LS_L2_WAIT, and loads presented there are ignored.
- R7: In LS_L2_WAIT a second-level hit completes the load with the returned data, destination clean, raises the first-level fill strobe, and returns to LS_IDLE.
- R8: In LS_L2_WAIT during runahead mode, a second-level miss completes the load poisoned with data 0. In the same cycle it raises the scheduler-remove and memory-prefetch strobes and returns to LS_IDLE.
- R9: In LS_L2_WAIT outside runahead mode, a second-level miss produces no completion and the machine keeps waiting.
- R10: In runahead mode each completed load writes its poison result to its destination flag, and each valid writeback lane writes its flag. Lane writes override the load write, and a higher-numbered lane overrides a lower one on the same register. The new flag is visible on the query port from the next cycle.
- R11: Outside runahead mode every poison flag is cleared at each clock edge, and all flag writes are ignored.
- R12: Pseudo-retire of the head is asserted only in runahead mode, when the head is valid and either poisoned or executed with its result written.
- R13: In runahead mode a scheduled poisoned store raises the store-buffer poison-set strobe. A clean store executing raises the poison-clear strobe, and also the store prefetch when it misses the data cache. Outside runahead mode none of these strobes rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runahead_mode | input | 1 | High while the core runs ahead |
| ld_valid | input | 1 | Load presented this cycle |
| ld_src_preg | input | PREG_W | Physical source register of the load |
| ld_dst_preg | input | PREG_W | Physical destination register of the load |
| ld_byte_mask | input | NBYTE | Bytes of the line the load reads |
| sb_hit | input | 1 | Store buffer lookup hit |
| sb_entry_inv | input | 1 | Hit store-buffer entry is poisoned |
| sb_data | input | DATA_W | Store buffer data |
| rc_hit | input | 1 | Runahead cache hit |
| rc_byte_inv | input | NBYTE | Per-byte poison bits from the runahead cache |
| rc_data | input | DATA_W | Runahead cache data |
| dc_hit | input | 1 | Data cache hit |
| dc_data | input | DATA_W | Data cache data |
| l2_resp_valid | input | 1 | Second-level outcome available |
| l2_hit | input | 1 | Second-level outcome was a hit |
| l2_data | input | DATA_W | Second-level data |
| wb_valid | input | NLANE | Writeback lane valid |
| wb_preg | input | NLANE*PREG_W | Writeback lane destinations, lane i at bits i*PREG_W |
| wb_inv | input | NLANE | Writeback lane result poisoned |
| chk_preg | input | PREG_W | Register queried for its poison flag |
| chk_inv | output | 1 | Poison flag of chk_preg |
| head_valid | input | 1 | Window head holds an instruction |
| head_inv | input | 1 | Head instruction is poisoned |
| head_executed | input | 1 | Head instruction executed and wrote back |
| head_pretire | output | 1 | Head may pseudo-retire |
| st_sched | input | 1 | Store scheduled this cycle |
| st_exec | input | 1 | Store executed this cycle |
| st_is_inv | input | 1 | The store is poisoned |
| st_dc_hit | input | 1 | The executing store hit the data cache |
| sb_inv_set | output | 1 | Set poison of the store-buffer entry |
| sb_inv_clr | output | 1 | Clear poison of the store-buffer entry |
| st_prefetch | output | 1 | Prefetch for a clean store that missed |
| ld_ready | output | 1 | Load engine accepts a load |
| ld_done | output | 1 | Load completes this cycle |
| ld_done_preg | output | PREG_W | Destination of the completing load |
| ld_data | output | DATA_W | Data of the completing load |
| ld_dst_inv | output | 1 | Completing load's destination is poisoned |
| l2_req | output | 1 | Request to the second-level cache |
| l1_fill | output | 1 | Fill the first-level cache from the second level |
| sched_remove | output | 1 | Remove the load from the scheduler |
| mem_prefetch | output | 1 | Send the missing line to memory as a prefetch |

## Verification
The bench goes after the priority corners. These are a store-buffer hit that is poisoned while the runahead cache and data cache also hit, and a runahead-cache hit whose poison bits fall only outside the byte mask. A resolver with the order swapped would return cache data for a poisoned store, and one that ignored the mask would poison clean loads. Two writeback lanes striking the same register in one cycle are provoked often. Getting that rule wrong leaves the flag from the wrong lane. The bench also presents a second-level miss outside runahead mode, where a design that poisons instead of stalling completes early. It toggles the mode so that stale poison flags surviving an exit would show on the query port.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef enum logic [0:0] {
        LS_IDLE,
        LS_L2_WAIT
    } ld_state_e;

    typedef enum logic [1:0] {
        FS_NONE,
        FS_SB,
        FS_RC,
        FS_DC
    } fwd_src_e;

endpackage

// File: rtl/ra_fwd_select.sv
module ra_fwd_select
    import ra_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NBYTE  = 4
) (
    input  logic              sb_hit,
    input  logic              sb_entry_inv,
    input  logic [DATA_W-1:0] sb_data,
    input  logic              rc_hit,
    input  logic [NBYTE-1:0]  rc_byte_inv,
    input  logic [NBYTE-1:0]  byte_mask,
    input  logic [DATA_W-1:0] rc_data,
    input  logic              dc_hit,
    input  logic [DATA_W-1:0] dc_data,
    output logic              sel_hit,
    output logic              sel_inv,
    output logic [DATA_W-1:0] sel_data
);

    fwd_src_e          src;
    logic              rc_poison;

    assign rc_poison = |(rc_byte_inv & byte_mask);

    always_comb begin
        if (sb_hit)      src = FS_SB;
        else if (rc_hit) src = FS_RC;
        else if (dc_hit) src = FS_DC;
        else             src = FS_NONE;
    end

    always_comb begin
        sel_hit  = 1'b1;
        sel_inv  = 1'b0;
        sel_data = '0;
        unique case (src)
            FS_SB: begin
                sel_inv  = sb_entry_inv;
                sel_data = sb_entry_inv ? '0 : sb_data;
            end
            FS_RC: begin
                sel_inv  = rc_poison;
                sel_data = rc_poison ? '0 : rc_data;
            end
            FS_DC: begin
                sel_data = dc_data;
            end
            FS_NONE: begin
                sel_hit = 1'b0;
            end
            default: sel_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ra_inv_file.sv
module ra_inv_file #(
    parameter int PREG_W = 6,
    parameter int NLANE  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    ld_we,
    input  logic [PREG_W-1:0]       ld_preg,
    input  logic                    ld_inv,
    input  logic [NLANE-1:0]        wb_valid,
    input  logic [NLANE*PREG_W-1:0] wb_preg,
    input  logic [NLANE-1:0]        wb_inv,
    input  logic [PREG_W-1:0]       rd_a_preg,
    output logic                    rd_a_inv,
    input  logic [PREG_W-1:0]       rd_b_preg,
    output logic                    rd_b_inv
);

    localparam int NREG = 1 << PREG_W;

    logic [NREG-1:0] inv_q;
    logic [NREG-1:0] inv_d;

    // Write order sets priority: load first, then lanes in ascending index.
    always_comb begin
        inv_d = inv_q;
        if (ld_we) inv_d[ld_preg] = ld_inv;
        for (int l = 0; l < NLANE; l++) begin
            if (wb_valid[l]) inv_d[wb_preg[l*PREG_W +: PREG_W]] = wb_inv[l];
        end
        if (clear) inv_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= '0;
        else        inv_q <= inv_d;
    end

    assign rd_a_inv = inv_q[rd_a_preg];
    assign rd_b_inv = inv_q[rd_b_preg];

endmodule

// File: rtl/ra_load_fsm.sv
module ra_load_fsm
    import ra_pkg::*;
#(
    parameter int PREG_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              runahead_mode,
    input  logic              ld_valid,
    input  logic [PREG_W-1:0] ld_dst_preg,
    input  logic              src_inv,
    input  logic              sel_hit,
    input  logic              sel_inv,
    input  logic [DATA_W-1:0] sel_data,
    input  logic              l2_resp_valid,
    input  logic              l2_hit,
    input  logic [DATA_W-1:0] l2_data,
    output logic              ld_ready,
    output logic              ld_done,
    output logic [PREG_W-1:0] ld_done_preg,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_dst_inv,
    output logic              l2_req,
    output logic              l1_fill,
    output logic              sched_remove,
    output logic              mem_prefetch
);

    ld_state_e         state_q, state_d;
    logic [PREG_W-1:0] dst_q, dst_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            dst_q   <= dst_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        dst_d        = dst_q;
        ld_ready     = 1'b0;
        ld_done      = 1'b0;
        ld_done_preg = dst_q;
        ld_data      = '0;
        ld_dst_inv   = 1'b0;
        l2_req       = 1'b0;
        l1_fill      = 1'b0;
        sched_remove = 1'b0;
        mem_prefetch = 1'b0;
        unique case (state_q)
            LS_IDLE: begin
                ld_ready     = 1'b1;
                ld_done_preg = ld_dst_preg;
                if (ld_valid) begin
                    if (src_inv) begin
                        ld_done    = 1'b1;
                        ld_dst_inv = 1'b1;
                    end else if (sel_hit) begin
                        ld_done    = 1'b1;
                        ld_dst_inv = sel_inv;
                        ld_data    = sel_data;
                    end else begin
                        // issue_l2
                        l2_req  = 1'b1;
                        dst_d   = ld_dst_preg;
                        state_d = LS_L2_WAIT;
                    end
                end
            end
            LS_L2_WAIT: begin
                if (l2_resp_valid) begin
                    if (l2_hit) begin
                        // l2_fill
                        ld_done = 1'b1;
                        ld_data = l2_data;
                        l1_fill = 1'b1;
                        state_d = LS_IDLE;
                    end else if (runahead_mode) begin
                        // l2_poison
                        ld_done      = 1'b1;
                        ld_dst_inv   = 1'b1;
                        sched_remove = 1'b1;
                        mem_prefetch = 1'b1;
                        state_d      = LS_IDLE;
                    end
                    // otherwise l2_stall: keep waiting
                end
            end
            default: state_d = LS_IDLE;
        endcase
    end

endmodule

// File: rtl/ra_head_store.sv
module ra_head_store (
    input  logic runahead_mode,
    input  logic head_valid,
    input  logic head_inv,
    input  logic head_executed,
    input  logic st_sched,
    input  logic st_exec,
    input  logic st_is_inv,
    input  logic st_dc_hit,
    output logic head_pretire,
    output logic sb_inv_set,
    output logic sb_inv_clr,
    output logic st_prefetch
);

    logic clean_exec;

    assign head_pretire = runahead_mode && head_valid && (head_inv || head_executed);
    assign clean_exec   = runahead_mode && st_exec && !st_is_inv;
    assign sb_inv_clr   = clean_exec;
    assign st_prefetch  = clean_exec && !st_dc_hit;
    assign sb_inv_set   = runahead_mode && st_sched && st_is_inv;

endmodule

// File: rtl/ra_load_resolve.sv
module ra_load_resolve #(
    parameter int PREG_W = 6,
    parameter int DATA_W = 32,
    parameter int NBYTE  = 4,
    parameter int NLANE  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    runahead_mode,
    input  logic                    ld_valid,
    input  logic [PREG_W-1:0]       ld_src_preg,
    input  logic [PREG_W-1:0]       ld_dst_preg,
    input  logic [NBYTE-1:0]        ld_byte_mask,
    input  logic                    sb_hit,
    input  logic                    sb_entry_inv,
    input  logic [DATA_W-1:0]       sb_data,
    input  logic                    rc_hit,
    input  logic [NBYTE-1:0]        rc_byte_inv,
    input  logic [DATA_W-1:0]       rc_data,
    input  logic                    dc_hit,
    input  logic [DATA_W-1:0]       dc_data,
    input  logic                    l2_resp_valid,
    input  logic                    l2_hit,
    input  logic [DATA_W-1:0]       l2_data,
    input  logic [NLANE-1:0]        wb_valid,
    input  logic [NLANE*PREG_W-1:0] wb_preg,
    input  logic [NLANE-1:0]        wb_inv,
    input  logic [PREG_W-1:0]       chk_preg,
    output logic                    chk_inv,
    input  logic                    head_valid,
    input  logic                    head_inv,
    input  logic                    head_executed,
    output logic                    head_pretire,
    input  logic                    st_sched,
    input  logic                    st_exec,
    input  logic                    st_is_inv,
    input  logic                    st_dc_hit,
    output logic                    sb_inv_set,
    output logic                    sb_inv_clr,
    output logic                    st_prefetch,
    output logic                    ld_ready,
    output logic                    ld_done,
    output logic [PREG_W-1:0]       ld_done_preg,
    output logic [DATA_W-1:0]       ld_data,
    output logic                    ld_dst_inv,
    output logic                    l2_req,
    output logic                    l1_fill,
    output logic                    sched_remove,
    output logic                    mem_prefetch
);

    logic              src_inv;
    logic              sel_hit;
    logic              sel_inv;
    logic [DATA_W-1:0] sel_data;

    ra_fwd_select #(.DATA_W(DATA_W), .NBYTE(NBYTE)) u_sel (
        .sb_hit      (sb_hit),
        .sb_entry_inv(sb_entry_inv),
        .sb_data     (sb_data),
        .rc_hit      (rc_hit),
        .rc_byte_inv (rc_byte_inv),
        .byte_mask   (ld_byte_mask),
        .rc_data     (rc_data),
        .dc_hit      (dc_hit),
        .dc_data     (dc_data),
        .sel_hit     (sel_hit),
        .sel_inv     (sel_inv),
        .sel_data    (sel_data)
    );

    ra_load_fsm #(.PREG_W(PREG_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .runahead_mode(runahead_mode),
        .ld_valid     (ld_valid),
        .ld_dst_preg  (ld_dst_preg),
        .src_inv      (src_inv),
        .sel_hit      (sel_hit),
        .sel_inv      (sel_inv),
        .sel_data     (sel_data),
        .l2_resp_valid(l2_resp_valid),
        .l2_hit       (l2_hit),
        .l2_data      (l2_data),
        .ld_ready     (ld_ready),
        .ld_done      (ld_done),
        .ld_done_preg (ld_done_preg),
        .ld_data      (ld_data),
        .ld_dst_inv   (ld_dst_inv),
        .l2_req       (l2_req),
        .l1_fill      (l1_fill),
        .sched_remove (sched_remove),
        .mem_prefetch (mem_prefetch)
    );

    ra_inv_file #(.PREG_W(PREG_W), .NLANE(NLANE)) u_inv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!runahead_mode),
        .ld_we    (ld_done),
        .ld_preg  (ld_done_preg),
        .ld_inv   (ld_dst_inv),
        .wb_valid (wb_valid),
        .wb_preg  (wb_preg),
        .wb_inv   (wb_inv),
        .rd_a_preg(ld_src_preg),
        .rd_a_inv (src_inv),
        .rd_b_preg(chk_preg),
        .rd_b_inv (chk_inv)
    );

    ra_head_store u_hs (
        .runahead_mode(runahead_mode),
        .head_valid   (head_valid),
        .head_inv     (head_inv),
        .head_executed(head_executed),
        .st_sched     (st_sched),
        .st_exec      (st_exec),
        .st_is_inv    (st_is_inv),
        .st_dc_hit    (st_dc_hit),
        .head_pretire (head_pretire),
        .sb_inv_set   (sb_inv_set),
        .sb_inv_clr   (sb_inv_clr),
        .st_prefetch  (st_prefetch)
    );

endmodule

// File: rtl/ra_load_resolve_chk.sv
module ra_load_resolve_chk (
    input logic clk,
    input logic rst_n,
    input logic runahead_mode,
    input logic ld_valid,
    input logic sb_hit,
    input logic rc_hit,
    input logic dc_hit,
    input logic l2_resp_valid,
    input logic l2_hit,
    input logic l2_req,
    input logic ld_ready,
    input logic ld_done,
    input logic ld_dst_inv,
    input logic l1_fill,
    input logic sched_remove,
    input logic mem_prefetch,
    input logic chk_inv,
    input logic head_valid,
    input logic head_inv,
    input logic head_executed,
    input logic head_pretire,
    input logic sb_inv_set,
    input logic sb_inv_clr
);

    p_l2_req_all_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req |-> ld_valid && !sb_hit && !rc_hit && !dc_hit);

    p_wait_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req |=> !ld_ready);

    p_fill_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l1_fill |-> ld_done && !ld_dst_inv && l2_resp_valid && l2_hit && !ld_ready);

    p_poison_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sched_remove |-> ld_done && ld_dst_inv && mem_prefetch && runahead_mode);

    p_stall_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ready && l2_resp_valid && !l2_hit && !runahead_mode) |-> !ld_done);

    p_normal_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !runahead_mode |=> !chk_inv);

    p_pretire_rule_r12: assert property (@(posedge clk) disable iff (!rst_n)
        head_pretire |-> runahead_mode && head_valid && (head_inv || head_executed));

    p_store_flags_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sb_inv_set, sb_inv_clr}));

endmodule

bind ra_load_resolve ra_load_resolve_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .runahead_mode(runahead_mode),
    .ld_valid     (ld_valid),
    .sb_hit       (sb_hit),
    .rc_hit       (rc_hit),
    .dc_hit       (dc_hit),
    .l2_resp_valid(l2_resp_valid),
    .l2_hit       (l2_hit),
    .l2_req       (l2_req),
    .ld_ready     (ld_ready),
    .ld_done      (ld_done),
    .ld_dst_inv   (ld_dst_inv),
    .l1_fill      (l1_fill),
    .sched_remove (sched_remove),
    .mem_prefetch (mem_prefetch),
    .chk_inv      (chk_inv),
    .head_valid   (head_valid),
    .head_inv     (head_inv),
    .head_executed(head_executed),
    .head_pretire (head_pretire),
    .sb_inv_set   (sb_inv_set),
    .sb_inv_clr   (sb_inv_clr)
);

// File: tb/test_ra_load_resolve.sv
module test_ra_load_resolve;

    localparam int PW = 6;
    localparam int DW = 32;
    localparam int NB = 4;
    localparam int NL = 2;
    localparam int NR = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic mode, ld_valid, sb_hit, sb_entry_inv, rc_hit, dc_hit, l2_resp_valid, l2_hit;
    logic [PW-1:0] ld_src, ld_dst, chk_preg;
    logic [NB-1:0] mask, rc_binv;
    logic [DW-1:0] sb_data, rc_data, dc_data, l2_data;
    logic [NL-1:0] wb_valid, wb_inv;
    logic [NL*PW-1:0] wb_preg;
    logic head_valid, head_inv, head_exec, st_sched, st_exec, st_is_inv, st_dc_hit;

    logic chk_inv, head_pretire, sb_inv_set, sb_inv_clr, st_prefetch;
    logic ld_ready, ld_done, ld_dst_inv, l2_req, l1_fill, sched_remove, mem_prefetch;
    logic [PW-1:0] ld_done_preg;
    logic [DW-1:0] ld_data;

    ra_load_resolve #(.PREG_W(PW), .DATA_W(DW), .NBYTE(NB), .NLANE(NL)) i_ra_load_resolve (
        .clk(clk), .rst_n(rst_n), .runahead_mode(mode),
        .ld_valid(ld_valid), .ld_src_preg(ld_src), .ld_dst_preg(ld_dst), .ld_byte_mask(mask),
        .sb_hit(sb_hit), .sb_entry_inv(sb_entry_inv), .sb_data(sb_data),
        .rc_hit(rc_hit), .rc_byte_inv(rc_binv), .rc_data(rc_data),
        .dc_hit(dc_hit), .dc_data(dc_data),
        .l2_resp_valid(l2_resp_valid), .l2_hit(l2_hit), .l2_data(l2_data),
        .wb_valid(wb_valid), .wb_preg(wb_preg), .wb_inv(wb_inv),
        .chk_preg(chk_preg), .chk_inv(chk_inv),
        .head_valid(head_valid), .head_inv(head_inv), .head_executed(head_exec),
        .head_pretire(head_pretire),
        .st_sched(st_sched), .st_exec(st_exec), .st_is_inv(st_is_inv), .st_dc_hit(st_dc_hit),
        .sb_inv_set(sb_inv_set), .sb_inv_clr(sb_inv_clr), .st_prefetch(st_prefetch),
        .ld_ready(ld_ready), .ld_done(ld_done), .ld_done_preg(ld_done_preg),
        .ld_data(ld_data), .ld_dst_inv(ld_dst_inv), .l2_req(l2_req), .l1_fill(l1_fill),
        .sched_remove(sched_remove), .mem_prefetch(mem_prefetch)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic          mv [NR];
    bit            m_wait;
    logic [PW-1:0] m_dst;

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic quiet();
        ld_valid = 0; ld_src = 0; ld_dst = 0; mask = 0;
        sb_hit = 0; sb_entry_inv = 0; sb_data = 0;
        rc_hit = 0; rc_binv = 0; rc_data = 0; dc_hit = 0; dc_data = 0;
        l2_resp_valid = 0; l2_hit = 0; l2_data = 0;
        wb_valid = 0; wb_preg = 0; wb_inv = 0; chk_preg = 0;
        head_valid = 0; head_inv = 0; head_exec = 0;
        st_sched = 0; st_exec = 0; st_is_inv = 0; st_dc_hit = 0;
    endtask

    // One cycle: inputs already set after a falling edge.
    task automatic step();
        logic e_ready, e_done, e_inv, e_l2, e_fill, e_rem, e_pf;
        logic [DW-1:0] e_data;
        logic [PW-1:0] e_dst;
        string tag;
        #1;
        e_ready = !m_wait; e_done = 0; e_inv = 0; e_l2 = 0; e_fill = 0;
        e_rem = 0; e_pf = 0; e_data = 0; e_dst = m_wait ? m_dst : ld_dst;
        tag = "R6 idle";
        if (!m_wait) begin
            if (ld_valid) begin
                if (mv[ld_src]) begin
                    tag = "R1 src poison"; e_done = 1; e_inv = 1;
                end else if (sb_hit) begin
                    tag = sb_entry_inv ? "R3 sb poison" : "R2 sb fwd";
                    e_done = 1; e_inv = sb_entry_inv; e_data = sb_entry_inv ? 0 : sb_data;
                end else if (rc_hit) begin
                    tag = "R4 rc fwd";
                    e_done = 1; e_inv = |(rc_binv & mask); e_data = e_inv ? 0 : rc_data;
                end else if (dc_hit) begin
                    tag = "R5 dc hit"; e_done = 1; e_data = dc_data;
                end else begin
                    tag = "R6 l2 issue"; e_l2 = 1;
                end
            end
        end else begin
            tag = "R6 wait";
            if (l2_resp_valid) begin
                if (l2_hit) begin
                    tag = "R7 l2 hit"; e_done = 1; e_data = l2_data; e_fill = 1;
                end else if (mode) begin
                    tag = "R8 l2 miss"; e_done = 1; e_inv = 1; e_rem = 1; e_pf = 1;
                end else begin
                    tag = "R9 stall";
                end
            end
        end
        chk({tag, " ready"}, ld_ready, e_ready);
        chk({tag, " done"}, ld_done, e_done);
        chk({tag, " l2_req"}, l2_req, e_l2);
        chk({tag, " fill"}, l1_fill, e_fill);
        chk({tag, " remove/prefetch"}, {sched_remove, mem_prefetch}, {e_rem, e_pf});
        if (e_done) begin
            chk({tag, " inv"}, ld_dst_inv, e_inv);
            chk({tag, " data"}, ld_data, e_data);
            chk({tag, " preg"}, ld_done_preg, e_dst);
        end
        chk("R10 query flag", chk_inv, mv[chk_preg]);
        chk("R12 pretire", head_pretire, mode & head_valid & (head_inv | head_exec));
        chk("R13 store flags", {sb_inv_set, sb_inv_clr, st_prefetch},
            {mode & st_sched & st_is_inv, mode & st_exec & !st_is_inv,
             mode & st_exec & !st_is_inv & !st_dc_hit});
        // model update
        if (!mode) begin
            for (int r = 0; r < NR; r++) mv[r] = 0;
        end else begin
            if (e_done) mv[e_dst] = e_inv;
            for (int l = 0; l < NL; l++)
                if (wb_valid[l]) mv[wb_preg[l*PW +: PW]] = wb_inv[l];
        end
        if (!m_wait && e_l2) begin m_wait = 1; m_dst = ld_dst; end
        else if (m_wait && e_done) m_wait = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rnd();
        ld_valid = ($urandom % 4) != 0;
        ld_src = PW'($urandom % 8); ld_dst = PW'($urandom % 8);
        mask = NB'($urandom); rc_binv = NB'($urandom % 3 == 0 ? $urandom : 0);
        sb_hit = ($urandom % 4) == 0; sb_entry_inv = $urandom % 2;
        rc_hit = ($urandom % 3) == 0; dc_hit = ($urandom % 2) == 0;
        sb_data = $urandom; rc_data = $urandom; dc_data = $urandom; l2_data = $urandom;
        l2_resp_valid = ($urandom % 3) == 0; l2_hit = $urandom % 2;
        wb_valid = NL'($urandom); wb_inv = NL'($urandom);
        for (int l = 0; l < NL; l++) wb_preg[l*PW +: PW] = PW'($urandom % 8);
        chk_preg = PW'($urandom % 8);
        head_valid = $urandom % 2; head_inv = $urandom % 2; head_exec = $urandom % 2;
        st_sched = $urandom % 2; st_exec = $urandom % 2;
        st_is_inv = $urandom % 2; st_dc_hit = $urandom % 2;
        if (($urandom % 40) == 0) mode = ~mode;
    endtask

    initial begin
        void'($urandom(32'h0005eed5));
        for (int r = 0; r < NR; r++) mv[r] = 0;
        m_wait = 0; m_dst = 0;
        mode = 1; quiet();
        repeat (3) @(negedge clk);
        #1;
        chk("R6 reset ready", ld_ready, 1);
        chk("R10 reset flag", chk_inv, 0);
        chk("R7 reset strobes", {ld_done, l2_req, l1_fill, sched_remove, mem_prefetch}, 0);
        rst_n = 1;
        @(negedge clk);

        // R10: two lanes on one register, higher lane wins
        quiet(); wb_valid = 2'b11; wb_preg = {PW'(5), PW'(5)}; wb_inv = 2'b01; step();
        quiet(); chk_preg = 5; step();
        quiet(); wb_valid = 2'b11; wb_preg = {PW'(5), PW'(5)}; wb_inv = 2'b10; step();
        quiet(); chk_preg = 5; step();
        // R1: poisoned source ignores a valid sb hit
        quiet(); ld_valid = 1; ld_src = 5; ld_dst = 3; sb_hit = 1; sb_data = 32'hAA; step();
        // R3: poisoned sb entry beats rc and dc
        quiet(); ld_valid = 1; ld_src = 1; ld_dst = 2; sb_hit = 1; sb_entry_inv = 1;
        rc_hit = 1; dc_hit = 1; rc_data = 7; dc_data = 8; step();
        // R4: poison outside mask has no effect
        quiet(); ld_valid = 1; ld_src = 1; ld_dst = 2; rc_hit = 1; rc_binv = 4'b1000;
        mask = 4'b0111; rc_data = 32'h1234; dc_hit = 1; step();
        quiet(); chk_preg = 2; step();
        // R9: normal-mode miss stalls, then a hit completes
        mode = 0; quiet(); ld_valid = 1; ld_src = 1; ld_dst = 4; step();
        quiet(); l2_resp_valid = 1; l2_hit = 0; step();
        quiet(); ld_valid = 1; ld_src = 1; dc_hit = 1; step();
        quiet(); l2_resp_valid = 1; l2_hit = 1; l2_data = 32'hBEEF; step();
        // R8: runahead-mode miss poisons
        mode = 1; quiet(); ld_valid = 1; ld_src = 1; ld_dst = 6; step();
        quiet(); l2_resp_valid = 1; step();
        quiet(); chk_preg = 6; step();

        for (int i = 0; i < 4000; i++) begin
            rnd();
            step();
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule